// File: doc/BRIEF.md
# NAND Flash Bus Cycle Generator

This block turns simple register-side requests into byte-wide bus cycles on a raw NAND flash device. A request names one of four cycle kinds: command byte, address byte, data write and data read. The block plays the request out as three timed phases. In the setup phase the latch-enable lines and the write data settle. In the strobe phase the write or read strobe is pulled low. In the hold phase the lines stay put after the strobe rises. Each phase length is a small programmable cycle count.

A single configuration word holds the controller enable, the chip-deselect control and the three phase lengths. Each length is stored as its cycle count minus one. The same word carries a self-clearing bit that emits a one-cycle pulse, which clears an external ECC accumulator. A synchronized copy of the flash ready/busy pin is also brought out. The block holds a busy flag while a cycle is in flight. A request can only be taken while that flag is low and the controller is enabled.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset the block reads back configuration with enable 0, deselect 1, setup field SETUP_MAX-1, strobe field 7 and hold field 7. It also shows busy 0, chip enable high, both strobes high, CLE/ALE low, data bus not driven and captured read byte 0x00.
- R2: A configuration write stores the word and reads it back unchanged. With the default parameters the layout is: bit 0 enable, bit 1 deselect, bits 3:2 setup field, bits 6:4 strobe field, bits 9:7 hold field. Bit 10 is the ECC-clear trigger and always reads as 0.
- R3: An accepted request makes busy high for exactly S+P+H cycles, starting the cycle after acceptance. S, P and H are each the matching field plus one. The first S cycles are setup, the next P are strobe and the last H are hold.
- R4: The request kind is encoded 0 = command, 1 = address, 2 = data write, 3 = data read. A command request holds CLE high and ALE low for the whole busy window. The write strobe is low only during the strobe phase.
- R5: An address request holds ALE high and CLE low for the whole busy window. The write strobe is low only during the strobe phase.
- R6: Command, address and data-write requests drive the request byte onto the bus, with output enable high for the whole busy window. A data write keeps CLE and ALE low.
- R7: A data-read request never drives the bus and never lowers the write strobe. Its read strobe is low only during the strobe phase. The bus byte is captured at the last strobe-phase edge and is visible from the first hold cycle onward.
- R8: A request presented while busy, or while the enable bit is 0, is dropped: no cycle ever follows from it.
- R9: The flash chip-enable output equals the stored deselect bit (1 = deselected, 0 = selected).
- R10: The ready status output equals the ready/busy pin as it was two clock edges earlier (1 = ready).
- R11: Writing the configuration word with bit 10 set gives a one-cycle ECC-clear pulse in the cycle right after the write, and the bit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | Configuration word to write |
| cfg_rdata | output | 11 | Stored configuration word |
| op_valid | input | 1 | Request a bus cycle |
| op_kind | input | 2 | Cycle kind: 0 cmd, 1 addr, 2 data write, 3 data read |
| op_data | input | 8 | Byte for command, address or data write |
| busy | output | 1 | Cycle in flight, requests are dropped |
| rd_data | output | 8 | Byte captured by the last data read |
| ready_stat | output | 1 | Synchronized flash ready status |
| ecc_clear | output | 1 | One-cycle pulse that clears the external ECC accumulator |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_nce | output | 1 | Chip enable, active low |
| nand_nwe | output | 1 | Write strobe, active low |
| nand_nre | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven by the block |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus byte sampled from the flash |
| nand_rb | input | 1 | Flash ready/busy pin, 1 = ready |

## Verification
The bench uses the default parameters: a setup limit of 4 cycles, strobe and hold limits of 8, and a two-stage ready synchronizer. With these values every field value is cheap to reach. This covers the one-cycle minimum in each phase, the 4/8/8 maximum and random mixes in between, across all four cycle kinds. Busy and the strobes are checked cycle by cycle against the phase counts. The bench also presents requests in the middle of a cycle and while the controller is disabled.

// File: rtl/nand_cyc_pkg.sv
// Shared types for the NAND bus cycle generator.
package nand_cyc_pkg;

    // Cycle kind carried by a request; encoding is visible at the top ports.
    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_WR   = 2'd2,
        KIND_RD   = 2'd3
    } kind_e;

    // Sequencer phase.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

endpackage

// File: rtl/nand_cfg_regs.sv
// Configuration register: enable, deselect and three minus-one phase fields.
// A set trigger bit in a write makes a one-cycle ECC-clear pulse and is not
// stored. Assumes writes are single-cycle strobes from the register side.
module nand_cfg_regs #(
    parameter int SW        = 2,
    parameter int PW        = 3,
    parameter int HW        = 3,
    parameter int SETUP_MAX = 4,
    parameter int STROBE_MAX = 8,
    parameter int HOLD_MAX  = 8,
    localparam int CFG_W    = 3 + SW + PW + HW,
    localparam int ECC_BIT  = CFG_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             en,
    output logic             desel,
    output logic [SW-1:0]    setup_f,
    output logic [PW-1:0]    strobe_f,
    output logic [HW-1:0]    hold_f,
    output logic             ecc_clear,
    output logic [CFG_W-1:0] cfg_rdata
);
    localparam int S_LO = 2;
    localparam int P_LO = S_LO + SW;
    localparam int H_LO = P_LO + PW;

    // Store the configuration fields; reset to enable off, deselected, slowest timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            desel    <= 1'b1;
            setup_f  <= SW'(SETUP_MAX - 1);
            strobe_f <= PW'(STROBE_MAX - 1);
            hold_f   <= HW'(HOLD_MAX - 1);
        end else if (cfg_wr) begin
            en       <= cfg_wdata[0];
            desel    <= cfg_wdata[1];
            setup_f  <= cfg_wdata[S_LO +: SW];
            strobe_f <= cfg_wdata[P_LO +: PW];
            hold_f   <= cfg_wdata[H_LO +: HW];
        end
    end

    // Emit the ECC-clear pulse one cycle after a write with the trigger bit.
    always_ff @(posedge clk) begin
        if (!rst_n) ecc_clear <= 1'b0;
        else        ecc_clear <= cfg_wr && cfg_wdata[ECC_BIT];
    end

    // Assemble the read-back word; the trigger bit always reads zero.
    always_comb begin
        cfg_rdata = {1'b0, hold_f, strobe_f, setup_f, desel, en};
    end

endmodule

// File: rtl/nand_rb_sync.sv
// Multi-stage synchronizer for the asynchronous flash ready/busy pin.
// Assumes the pin is slow against the clock; reset value reads as busy.
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_pin,
    output logic rb_sync
);
    logic [STAGES-1:0] chain;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], rb_pin};
    end

    // Present the last stage.
    always_comb rb_sync = chain[STAGES-1];

endmodule

// File: rtl/nand_phase_seq.sv
// Three-phase bus cycle sequencer. On start it latches the kind, the byte and
// the three phase lengths, then runs setup, strobe and hold for field+1
// cycles each. Read data is captured on the last strobe edge. Assumes start
// only pulses while idle.
module nand_phase_seq
    import nand_cyc_pkg::*;
#(
    parameter int SW    = 2,
    parameter int PW    = 3,
    parameter int HW    = 3,
    parameter int CNT_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  kind_e         kind_in,
    input  logic [7:0]    byte_in,
    input  logic [SW-1:0] setup_f,
    input  logic [PW-1:0] strobe_f,
    input  logic [HW-1:0] hold_f,
    input  logic [7:0]    dq_in,
    output logic          busy,
    output logic          cle,
    output logic          ale,
    output logic          nwe,
    output logic          nre,
    output logic          dq_oe,
    output logic [7:0]    dq_out,
    output logic [7:0]    rd_data
);
    phase_e             phase;
    kind_e              kind;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   len_s, len_p, len_h;
    logic [7:0]         wbyte;
    logic               last;

    // Select the terminal count of the current phase.
    always_comb begin
        unique case (phase)
            PH_SETUP:  last = (cnt == len_s);
            PH_STROBE: last = (cnt == len_p);
            PH_HOLD:   last = (cnt == len_h);
            default:   last = 1'b0;
        endcase
    end

    // Advance phase and counter; latch the request on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            kind  <= KIND_CMD;
            cnt   <= '0;
            len_s <= '0;
            len_p <= '0;
            len_h <= '0;
            wbyte <= '0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase <= PH_SETUP;
                kind  <= kind_in;
                wbyte <= byte_in;
                cnt   <= '0;
                len_s <= CNT_W'(setup_f);
                len_p <= CNT_W'(strobe_f);
                len_h <= CNT_W'(hold_f);
            end
        end else if (last) begin
            cnt <= '0;
            unique case (phase)
                PH_SETUP:  phase <= PH_STROBE;
                PH_STROBE: phase <= PH_HOLD;
                default:   phase <= PH_IDLE;
            endcase
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Capture the bus byte on the closing edge of a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (phase == PH_STROBE && last && kind == KIND_RD)
            rd_data <= dq_in;
    end

    // Decode the bus controls from phase and kind.
    always_comb begin
        busy   = (phase != PH_IDLE);
        cle    = busy && (kind == KIND_CMD);
        ale    = busy && (kind == KIND_ADDR);
        dq_oe  = busy && (kind != KIND_RD);
        nwe    = !((phase == PH_STROBE) && (kind != KIND_RD));
        nre    = !((phase == PH_STROBE) && (kind == KIND_RD));
        dq_out = wbyte;
    end

endmodule

// File: rtl/nand_cycle_gen.sv
// Top of the NAND bus cycle generator: configuration register, ready
// synchronizer and phase sequencer. A request is taken only when enabled
// and idle; otherwise it is dropped.
module nand_cycle_gen
    import nand_cyc_pkg::*;
#(
    parameter int SETUP_MAX  = 4,
    parameter int STROBE_MAX = 8,
    parameter int HOLD_MAX   = 8,
    parameter int RB_STAGES  = 2,
    localparam int SW        = $clog2(SETUP_MAX),
    localparam int PW        = $clog2(STROBE_MAX),
    localparam int HW        = $clog2(HOLD_MAX),
    localparam int CFG_W     = 3 + SW + PW + HW,
    localparam int LMAX_A    = (SETUP_MAX > STROBE_MAX) ? SETUP_MAX : STROBE_MAX,
    localparam int LMAX      = (LMAX_A > HOLD_MAX) ? LMAX_A : HOLD_MAX,
    localparam int CNT_W     = $clog2(LMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [7:0]       op_data,
    output logic             busy,
    output logic [7:0]       rd_data,
    output logic             ready_stat,
    output logic             ecc_clear,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_nce,
    output logic             nand_nwe,
    output logic             nand_nre,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb
);
    logic          cfg_en;
    logic          cfg_desel;
    logic [SW-1:0] setup_f;
    logic [PW-1:0] strobe_f;
    logic [HW-1:0] hold_f;
    logic          start;

    nand_cfg_regs #(
        .SW(SW), .PW(PW), .HW(HW),
        .SETUP_MAX(SETUP_MAX), .STROBE_MAX(STROBE_MAX), .HOLD_MAX(HOLD_MAX)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .en(cfg_en), .desel(cfg_desel),
        .setup_f(setup_f), .strobe_f(strobe_f), .hold_f(hold_f),
        .ecc_clear(ecc_clear), .cfg_rdata(cfg_rdata)
    );

    nand_rb_sync #(.STAGES(RB_STAGES)) u_rb (
        .clk(clk), .rst_n(rst_n), .rb_pin(nand_rb), .rb_sync(ready_stat)
    );

    // Accept a request only when enabled and idle.
    always_comb start = op_valid && cfg_en && !busy;

    nand_phase_seq #(.SW(SW), .PW(PW), .HW(HW), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .kind_in(kind_e'(op_kind)), .byte_in(op_data),
        .setup_f(setup_f), .strobe_f(strobe_f), .hold_f(hold_f),
        .dq_in(nand_dq_in),
        .busy(busy), .cle(nand_cle), .ale(nand_ale),
        .nwe(nand_nwe), .nre(nand_nre),
        .dq_oe(nand_dq_oe), .dq_out(nand_dq_out), .rd_data(rd_data)
    );

    // Chip enable follows the stored deselect bit.
    always_comb nand_nce = cfg_desel;

endmodule

// File: rtl/nand_cycle_gen_chk.sv
// Protocol checker for the NAND bus cycle generator, bound to the top.
module nand_cycle_gen_chk #(
    parameter int CFG_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             busy,
    input logic             ecc_clear,
    input logic             nand_cle,
    input logic             nand_ale,
    input logic             nand_nwe,
    input logic             nand_nre,
    input logic             nand_dq_oe,
    input logic [7:0]       nand_dq_out
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_nwe && nand_nre && !nand_cle && !nand_ale && !nand_dq_oe));

    p_latch_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dq_oe)));

    p_cle_ale_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_byte_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && nand_dq_oe) |-> $stable(nand_dq_out));

    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!nand_nwe, !nand_nre}));

    p_read_undriven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_nre |-> !nand_dq_oe);

    p_start_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(cfg_en));

    p_ecc_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clear |-> $past(cfg_wr && cfg_wdata[CFG_W-1]));

endmodule

bind nand_cycle_gen nand_cycle_gen_chk #(.CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .busy(busy), .ecc_clear(ecc_clear),
    .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_nwe(nand_nwe), .nand_nre(nand_nre),
    .nand_dq_oe(nand_dq_oe), .nand_dq_out(nand_dq_out)
);

// File: tb/nand_cycle_gen_bench.sv
// Self-checking bench for nand_cycle_gen with default parameters.
module nand_cycle_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic [10:0] cfg_rdata;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [7:0]  op_data = '0;
    logic        busy;
    logic [7:0]  rd_data;
    logic        ready_stat;
    logic        ecc_clear;
    logic        nand_cle, nand_ale, nand_nce, nand_nwe, nand_nre, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    nand_cycle_gen u_nand_cycle_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .op_valid(op_valid), .op_kind(op_kind), .op_data(op_data),
        .busy(busy), .rd_data(rd_data), .ready_stat(ready_stat),
        .ecc_clear(ecc_clear),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_nce(nand_nce),
        .nand_nwe(nand_nwe), .nand_nre(nand_nre),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Phase expected in cycle k after acceptance: 0 idle,1 setup,2 strobe,3 hold.
    function automatic int exp_phase(int k, int s, int p, int h);
        if (k < 1)          return 0;
        if (k <= s)         return 1;
        if (k <= s + p)     return 2;
        if (k <= s + p + h) return 3;
        return 0;
    endfunction

    function automatic logic [10:0] cfg_word(bit en, bit ds, int sf, int pf, int hf, bit ecc);
        return {ecc, 3'(hf), 3'(pf), 2'(sf), ds, en};
    endfunction

    int cur_s = 4, cur_p = 8, cur_h = 8;

    task automatic write_cfg(bit en, bit ds, int sf, int pf, int hf, bit ecc);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = cfg_word(en, ds, sf, pf, hf, ecc);
        @(negedge clk);
        cfg_wr = 1'b0;
        cur_s = sf + 1; cur_p = pf + 1; cur_h = hf + 1;
        chk("R2 cfg readback", int'(cfg_rdata), int'(cfg_word(en, ds, sf, pf, hf, 1'b0)));
        chk("R9 nce follows deselect", int'(nand_nce), int'(ds));
        if (ecc) begin
            chk("R11 ecc pulse high", int'(ecc_clear), 1);
            @(negedge clk);
            chk("R11 ecc pulse ends", int'(ecc_clear), 0);
        end
    endtask

    // Issue one request and check every cycle of it; optionally inject a
    // second request mid-cycle that must be dropped.
    task automatic run_op(int kind, logic [7:0] b, logic [7:0] rdb, bit inject);
        int t;
        t = cur_s + cur_p + cur_h;
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'(kind); op_data = b; nand_dq_in = rdb;
        for (int k = 1; k <= t + 1; k++) begin
            int ph;
            @(negedge clk);
            if (k == 1) op_valid = 1'b0;
            if (inject && k == 2) begin
                op_valid = 1'b1; op_kind = 2'((kind + 1) % 4); op_data = ~b;
            end
            if (inject && k == 3) op_valid = 1'b0;
            ph = exp_phase(k, cur_s, cur_p, cur_h);
            chk("R3 busy window", int'(busy), int'(ph != 0));
            chk("R4 cle level", int'(nand_cle), int'(ph != 0 && kind == 0));
            chk("R5 ale level", int'(nand_ale), int'(ph != 0 && kind == 1));
            chk("R4 R5 R6 nwe strobe", int'(nand_nwe), int'(!(ph == 2 && kind != 3)));
            chk("R7 nre strobe", int'(nand_nre), int'(!(ph == 2 && kind == 3)));
            chk("R6 R7 bus drive", int'(nand_dq_oe), int'(ph != 0 && kind != 3));
            if (ph != 0 && kind != 3) chk("R6 bus byte", int'(nand_dq_out), int'(b));
            if (kind == 3 && ph == 3) chk("R7 captured byte", int'(rd_data), int'(rdb));
        end
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R8 request during busy dropped", int'(busy), 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset cfg", int'(cfg_rdata), int'(cfg_word(1'b0, 1'b1, 3, 7, 7, 1'b0)));
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset nce", int'(nand_nce), 1);
        chk("R1 reset strobes", int'({nand_nwe, nand_nre}), 3);
        chk("R1 reset latches", int'({nand_cle, nand_ale, nand_dq_oe}), 0);
        chk("R1 reset rd_data", int'(rd_data), 0);

        // R8: disabled controller drops requests
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd0; op_data = 8'h70;
        @(negedge clk);
        op_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R8 disabled request dropped", int'(busy), 0);
            @(negedge clk);
        end

        // R10: ready status two edges late
        @(negedge clk);
        nand_rb = 1'b1;
        @(negedge clk);
        chk("R10 ready after one edge", int'(ready_stat), 0);
        @(negedge clk);
        chk("R10 ready after two edges", int'(ready_stat), 1);
        nand_rb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 busy after two edges", int'(ready_stat), 0);

        // Directed: maximum timing, each kind
        write_cfg(1'b1, 1'b0, 3, 7, 7, 1'b0);
        run_op(0, 8'h90, 8'h00, 1'b0);
        run_op(1, 8'h3c, 8'h00, 1'b0);
        run_op(2, 8'ha5, 8'h00, 1'b0);
        run_op(3, 8'h00, 8'h5a, 1'b0);
        // Directed: minimum timing, ECC trigger
        write_cfg(1'b1, 1'b0, 0, 0, 0, 1'b1);
        run_op(3, 8'h00, 8'hc3, 1'b0);
        run_op(0, 8'hff, 8'h00, 1'b0);
        run_op(2, 8'h01, 8'h00, 1'b1);
        // Directed: request injected during busy, then deselect
        write_cfg(1'b1, 1'b0, 1, 2, 1, 1'b0);
        run_op(1, 8'h12, 8'h00, 1'b1);
        write_cfg(1'b1, 1'b1, 1, 2, 1, 1'b0);

        // Random mix
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 0)
                write_cfg(1'b1, 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                          $urandom_range(0, 7), $urandom_range(0, 7),
                          1'($urandom_range(0, 1)));
            run_op($urandom_range(0, 3), 8'($urandom), 8'($urandom),
                   1'($urandom_range(0, 3) == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule